// File: doc/BRIEF.md
# ECC Page Write Buffer

This block sits between a serial-memory protocol engine and a byte-addressed non-volatile array that is physically organised as 32-bit words, each stored with 6 Hamming check bits. The engine hands it the data bytes of one page write, one strobe per byte. The block stages them in a page-sized buffer with a per-byte valid mask. On a commit trigger it enters a timed busy cycle. During that cycle it walks the page's words in ascending order. For each word that holds a staged byte, it fetches the stored codeword, corrects it, merges in the staged bytes, re-encodes the result and stores it back.

Byte reads come from the internal address counter or from an explicit address. They return data that has passed single-error correction, and each read advances the counter. After a commit the counter points just past the last byte staged. An abort throws the staged page away. The array itself lives outside the block behind a simple word port with one cycle of read latency.

Top module: `ecc_page_writer`

## Requirements
- R1: After reset, busy and rd_valid are low, addr_cnt is zero and no memory access is issued.
- R2: The first accepted byte of a session fixes the row (address bits above PAGE_W) and the start offset (the low PAGE_W bits). Each later byte in the session ignores wr_addr and goes to the next offset, and only the low PAGE_W bits count, so the offset wraps inside the row.
- R3: If a session stages more bytes than a page holds, the offset wraps and the later bytes replace the earlier ones at the same offsets; the last byte written to an offset is the one committed.
- R4: A commit stores each word of the row that holds at least one staged byte exactly once, in ascending word order. Within a stored word, bytes that were not staged keep their previously stored (corrected) values. Words with no staged byte are neither fetched nor stored.
- R5: A stored codeword holds data in bits [31:0], with the byte at word offset b in bits [8b+7:8b], and check bits in [37:32]. Data bit d sits at Hamming position p(d), which is the (d+1)-th integer in 1..38 that is not a power of two. Check bit i is the parity of all data bits whose p(d) has bit i set.
- R6: A read returns the correct byte when any single one of the 38 stored bits of its word is flipped.
- R7: busy rises on the cycle after an accepted commit and stays high for exactly WRITE_CYCLES cycles when the word walk fits inside that time. While busy is high, wr_stb, commit, abort and rd_req are ignored.
- R8: When a commit ends, addr_cnt equals the row concatenated with the in-row offset that follows the last staged byte.
- R9: An abort empties the buffer and leaves the array and addr_cnt unchanged. A commit with an empty buffer is ignored, and busy stays low.
- R10: rd_req with rd_load set reads rd_addr; without rd_load it reads addr_cnt. rd_data is valid on the single cycle rd_valid is high. addr_cnt then holds the read address plus one, wrapping from the top address to zero.
- R11: When several requests arrive in the same idle cycle, the order of precedence is abort, then commit, then wr_stb, then rd_req. A request that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Stage one data byte |
| wr_addr | input | ADDR_W | Byte address; used only on the first byte of a session |
| wr_data | input | 8 | Byte to stage |
| commit | input | 1 | Start the commit cycle |
| abort | input | 1 | Discard the staged page |
| rd_req | input | 1 | Request one byte read |
| rd_load | input | 1 | Read from rd_addr instead of the counter |
| rd_addr | input | ADDR_W | Explicit read address |
| busy | output | 1 | Commit cycle in progress |
| rd_valid | output | 1 | rd_data valid pulse |
| rd_data | output | 8 | Corrected read byte |
| addr_cnt | output | ADDR_W | Internal address counter |
| mem_en | output | 1 | Array access enable |
| mem_we | output | 1 | Array store (else fetch) |
| mem_addr | output | ADDR_W-2 | Array word address |
| mem_wdata | output | 38 | Codeword to store |
| mem_rdata | input | 38 | Codeword fetched, one cycle after mem_en |

## Verification
The bench attacks a session that starts near the end of a row and wraps. A design that carried the increment into the row bits would store into the neighbouring row. It then overfills a page, so that a design keeping the first byte of a wrapped offset returns stale data. It rewrites a single byte inside a fully written row: a design that skips the merge, or stores untouched words, destroys the neighbouring bytes or shows the wrong number of word stores. It flips every one of the 38 bits of a stored word in turn, which exposes any mismatch in Hamming position or in check-bit placement as a wrong byte. It also checks the counter wrap, the exact busy length, requests issued during busy, and the precedence of requests that arrive together.

// File: rtl/epw_pkg.sv
package epw_pkg;

  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_TAKE,
    ST_C_SCAN,
    ST_C_FETCH,
    ST_C_STORE,
    ST_C_HOLD
  } epw_state_e;

  // Hamming position of data bit d: the (d+1)-th non-power-of-two in 1..CW_W
  function automatic logic [CHK_W-1:0] ecc_pos(input int d);
    logic [CHK_W-1:0] r;
    int c;
    r = '0;
    c = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (c == d) r = CHK_W'(p);
        c++;
      end
    end
    return r;
  endfunction

  // check bit i = parity of the data bits whose position has bit i set
  function automatic logic [CHK_W-1:0] ecc_check(input logic [DATA_W-1:0] data);
    logic [CHK_W-1:0] chk;
    logic [CHK_W-1:0] pos;
    chk = '0;
    for (int i = 0; i < CHK_W; i++) begin
      for (int d = 0; d < DATA_W; d++) begin
        pos = ecc_pos(d);
        if (pos[i]) chk[i] = chk[i] ^ data[d];
      end
    end
    return chk;
  endfunction

endpackage

// File: rtl/epw_ecc_enc.sv
module epw_ecc_enc
  import epw_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  assign chk_o = ecc_check(data_i);
endmodule

// File: rtl/epw_ecc_dec.sv
module epw_ecc_dec
  import epw_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o
);
  logic [CHK_W-1:0] syn;

  always_comb begin
    syn    = ecc_check(cw_i[DATA_W-1:0]) ^ cw_i[CW_W-1:DATA_W];
    data_o = cw_i[DATA_W-1:0];
    for (int d = 0; d < DATA_W; d++) begin
      if (syn != '0 && ecc_pos(d) == syn) data_o[d] = ~cw_i[d];
    end
  end
endmodule

// File: rtl/epw_buffer.sv
module epw_buffer #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [7:0]                   wr_data_i,
  input  logic                         clr_i,
  output logic [ADDR_W-PAGE_W-1:0]     row_o,
  output logic [PAGE_W-1:0]            ptr_o,
  output logic [(1<<PAGE_W)-1:0]       mask_o,
  output logic [(1<<PAGE_W)*8-1:0]     bytes_o
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic              sess_q;
  logic [ROW_W-1:0]  row_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PAGE-1:0]   mask_q;
  logic [7:0]        slot_q [PAGE];
  logic [PAGE_W-1:0] off;

  // first byte of a session takes its offset from the address
  assign off = sess_q ? ptr_q : wr_addr_i[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q <= 1'b0;
      row_q  <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      sess_q <= 1'b0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      if (!sess_q) row_q <= wr_addr_i[ADDR_W-1:PAGE_W];
      sess_q      <= 1'b1;
      mask_q[off] <= 1'b1;
      ptr_q       <= off + PAGE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i && !clr_i) slot_q[off] <= wr_data_i;
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_flat
    assign bytes_o[g*8 +: 8] = slot_q[g];
  end

  assign row_o  = row_q;
  assign ptr_o  = ptr_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/ecc_page_writer.sv
module ecc_page_writer
  import epw_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PAGE_W       = 8,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                commit,
  input  logic                abort,
  input  logic                rd_req,
  input  logic                rd_load,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                busy,
  output logic                rd_valid,
  output logic [7:0]          rd_data,
  output logic [ADDR_W-1:0]   addr_cnt,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [CW_W-1:0]     mem_wdata,
  input  logic [CW_W-1:0]     mem_rdata
);
  localparam int PAGE    = 1 << PAGE_W;
  localparam int ROW_W   = ADDR_W - PAGE_W;
  localparam int WORD_AW = ADDR_W - 2;
  localparam int WIDX_W  = PAGE_W - 2;
  localparam int TMR_W   = $clog2(WRITE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WRITE_CYCLES - 1);

  epw_state_e         state_q;
  logic [WIDX_W-1:0]  widx_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [ADDR_W-1:0]  cnt_q;
  logic [WORD_AW-1:0] rd_word_q;
  logic [1:0]         lane_q;
  logic [7:0]         rd_data_q;
  logic               rd_valid_q;

  logic [ROW_W-1:0]   row_w;
  logic [PAGE_W-1:0]  ptr_w;
  logic [PAGE-1:0]    mask_w;
  logic [PAGE*8-1:0]  bytes_w;
  logic [DATA_W-1:0]  fix_data;
  logic [DATA_W-1:0]  merged;
  logic [CHK_W-1:0]   merged_chk;
  logic [3:0]         word_mask;
  logic [ADDR_W-1:0]  rd_pick;

  // named internal events, used by the checker
  logic idle, last_word;
  logic evt_abort, evt_commit_start, evt_wr_accept, evt_rd_accept, evt_commit_done;

  assign idle             = (state_q == ST_IDLE);
  assign evt_abort        = idle && abort;
  assign evt_commit_start = idle && !abort && commit && (mask_w != '0);
  assign evt_wr_accept    = idle && !abort && !commit && wr_stb;
  assign evt_rd_accept    = idle && !abort && !commit && !wr_stb && rd_req;
  assign evt_commit_done  = (state_q == ST_C_HOLD) && (tmr_q == '0);
  assign last_word        = (widx_q == {WIDX_W{1'b1}});
  assign word_mask        = mask_w[{widx_q, 2'b00} +: 4];
  assign rd_pick          = rd_load ? rd_addr : cnt_q;

  epw_buffer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (evt_wr_accept),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .clr_i     (evt_abort || evt_commit_done),
    .row_o     (row_w),
    .ptr_o     (ptr_w),
    .mask_o    (mask_w),
    .bytes_o   (bytes_w)
  );

  epw_ecc_dec u_dec (.cw_i(mem_rdata), .data_o(fix_data));

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      merged[b*8 +: 8] = word_mask[b] ? bytes_w[{widx_q, 2'(b), 3'b000} +: 8]
                                      : fix_data[b*8 +: 8];
    end
  end

  epw_ecc_enc u_enc (.data_i(merged), .chk_o(merged_chk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      widx_q     <= '0;
      tmr_q      <= '0;
      cnt_q      <= '0;
      rd_word_q  <= '0;
      lane_q     <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      if (busy && tmr_q != '0) tmr_q <= tmr_q - TMR_W'(1);
      unique case (state_q)
        ST_IDLE: begin
          if (evt_commit_start) begin
            state_q <= ST_C_SCAN;
            widx_q  <= '0;
            tmr_q   <= TMR_LOAD;
          end else if (evt_rd_accept) begin
            state_q   <= ST_RD_ISSUE;
            rd_word_q <= rd_pick[ADDR_W-1:2];
            lane_q    <= rd_pick[1:0];
            cnt_q     <= rd_pick + ADDR_W'(1);
          end
        end
        ST_RD_ISSUE: state_q <= ST_RD_TAKE;
        ST_RD_TAKE: begin
          rd_data_q  <= fix_data[{lane_q, 3'b000} +: 8];
          rd_valid_q <= 1'b1;
          state_q    <= ST_IDLE;
        end
        ST_C_SCAN: begin
          if (word_mask != 4'b0000) state_q <= ST_C_FETCH;
          else if (last_word)       state_q <= ST_C_HOLD;
          else                      widx_q  <= widx_q + WIDX_W'(1);
        end
        ST_C_FETCH: state_q <= ST_C_STORE;
        ST_C_STORE: begin
          if (last_word) state_q <= ST_C_HOLD;
          else begin
            widx_q  <= widx_q + WIDX_W'(1);
            state_q <= ST_C_SCAN;
          end
        end
        ST_C_HOLD: begin
          if (tmr_q == '0) begin
            state_q <= ST_IDLE;
            cnt_q   <= {row_w, ptr_w};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == ST_C_SCAN) || (state_q == ST_C_FETCH) ||
                     (state_q == ST_C_STORE) || (state_q == ST_C_HOLD);
  assign mem_en    = (state_q == ST_RD_ISSUE) || (state_q == ST_C_FETCH) ||
                     (state_q == ST_C_STORE);
  assign mem_we    = (state_q == ST_C_STORE);
  assign mem_addr  = (state_q == ST_RD_ISSUE) ? rd_word_q : {row_w, widx_q};
  assign mem_wdata = {merged_chk, merged};
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign addr_cnt  = cnt_q;
endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
  parameter int ADDR_W       = 17,
  parameter int PAGE_W       = 8,
  parameter int WRITE_CYCLES = 250000
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      busy,
  input logic                      commit,
  input logic                      rd_valid,
  input logic                      mem_we,
  input logic [ADDR_W-3:0]         mem_addr,
  input logic [ADDR_W-1:0]         addr_cnt,
  input logic [ADDR_W-PAGE_W-1:0]  row,
  input logic [PAGE_W-1:0]         ptr,
  input logic [(1<<PAGE_W)-1:0]    mask,
  input logic                      evt_abort,
  input logic                      evt_commit_done,
  input logic                      evt_wr_accept,
  input logic                      evt_rd_accept
);
  localparam int WORD_AW = ADDR_W - 2;
  localparam int WIDX_W  = PAGE_W - 2;

  logic [31:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else           run_q <= '0;
  end

  assert_busy_needs_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));
  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == 32'(WRITE_CYCLES));
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!evt_wr_accept && !evt_rd_accept && !rd_valid));
  assert_store_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[WORD_AW-1:WIDX_W] == row);
  assert_store_marked_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mask[{mem_addr[WIDX_W-1:0], 2'b00} +: 4] != 4'b0000);
  assert_store_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> (mask == '0) && $stable(addr_cnt));
  assert_cnt_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit_done |=> addr_cnt == {$past(row), $past(ptr)});
endmodule

bind ecc_page_writer epw_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy            (busy),
  .commit          (commit),
  .rd_valid        (rd_valid),
  .mem_we          (mem_we),
  .mem_addr        (mem_addr),
  .addr_cnt        (addr_cnt),
  .row             (row_w),
  .ptr             (ptr_w),
  .mask            (mask_w),
  .evt_abort       (evt_abort),
  .evt_commit_done (evt_commit_done),
  .evt_wr_accept   (evt_wr_accept),
  .evt_rd_accept   (evt_rd_accept)
);

// File: tb/ecc_page_writer_tb.sv
module ecc_page_writer_tb;
  localparam int AW    = 10;
  localparam int PW    = 4;
  localparam int WCYC  = 20;
  localparam int PAGE  = 1 << PW;
  localparam int NBYTE = 1 << AW;
  localparam int NWORD = NBYTE / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, commit = 1'b0, abort = 1'b0, rd_req = 1'b0, rd_load = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, rd_valid, mem_en, mem_we;
  logic [7:0] rd_data;
  logic [AW-1:0] addr_cnt;
  logic [AW-3:0] mem_addr;
  logic [37:0] mem_wdata;
  logic [37:0] mem_rdata = '0;

  always #10 clk = ~clk;

  ecc_page_writer #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .abort(abort), .rd_req(rd_req), .rd_load(rd_load), .rd_addr(rd_addr),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .addr_cnt(addr_cnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // codeword = {XOR of Hamming positions of set data bits, data}
  function automatic logic [37:0] tb_pack(input logic [31:0] d);
    int p;
    logic [5:0] acc;
    p = 0;
    acc = '0;
    for (int k = 0; k < 32; k++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
      if (d[k]) acc = acc ^ 6'(p);
    end
    return {acc, d};
  endfunction

  // behavioural array: one-cycle read latency, bit-flip injection
  logic [37:0] arr [NWORD];
  logic inj_en = 1'b0;
  logic [7:0] inj_w = '0;
  logic [37:0] inj_mask = '0;
  int wcnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) arr[i] <= tb_pack(32'hFFFF_FFFF);
    end else begin
      if (mem_en && mem_we) begin
        arr[mem_addr] <= mem_wdata;
        wcnt <= wcnt + 1;
      end else if (mem_en) begin
        mem_rdata <= arr[mem_addr];
      end
      if (inj_en) arr[inj_w] <= arr[inj_w] ^ inj_mask;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [NBYTE];
  logic [7:0] st_data [PAGE];
  bit st_val [PAGE];
  int st_row, st_off;
  bit st_open;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic stage_clear();
    st_open = 1'b0;
    for (int i = 0; i < PAGE; i++) st_val[i] = 1'b0;
  endtask

  task automatic put(input int a, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    if (!st_open) begin st_row = a / PAGE; st_off = a % PAGE; st_open = 1'b1; end
    st_data[st_off] = d;
    st_val[st_off]  = 1'b1;
    st_off = (st_off + 1) % PAGE;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic do_commit(input string tag);
    int words, w0, n, ecnt;
    words = 0;
    for (int w = 0; w < PAGE / 4; w++)
      if (st_val[4*w] || st_val[4*w+1] || st_val[4*w+2] || st_val[4*w+3]) words++;
    for (int i = 0; i < PAGE; i++) if (st_val[i]) model[st_row*PAGE + i] = st_data[i];
    ecnt = st_row * PAGE + st_off;
    stage_clear();
    w0 = wcnt;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    wait_busy(n);
    chk(n == WCYC, {"R7 busy length ", tag}, n, WCYC);
    chk(wcnt - w0 == words, {"R4 words stored ", tag}, wcnt - w0, words);
    chk(addr_cnt == AW'(ecnt), {"R8 addr_cnt after commit ", tag}, int'(addr_cnt), ecnt);
  endtask

  task automatic rd(input bit load, input int a, output logic [7:0] v);
    int k;
    rd_req = 1'b1; rd_load = load; rd_addr = AW'(a);
    @(negedge clk);
    rd_req = 1'b0; rd_load = 1'b0;
    k = 0;
    while (!rd_valid && k < 10) begin k++; @(negedge clk); end
    v = rd_data;
    @(negedge clk);
  endtask

  task automatic check_row(input int row, input string tag);
    logic [7:0] v;
    for (int o = 0; o < PAGE; o++) begin
      rd(1'b1, row*PAGE + o, v);
      chk(v == model[row*PAGE + o], tag, int'(v), int'(model[row*PAGE + o]));
    end
  endtask

  task automatic flip(input int w, input int b);
    inj_en = 1'b1; inj_w = 8'(w); inj_mask = 38'd1 << b;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    int n;
    bit saw_rd;
    for (int i = 0; i < NBYTE; i++) model[i] = 8'hFF;
    stage_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(addr_cnt == '0, "R1 addr_cnt", int'(addr_cnt), 0);
    chk(mem_en == 1'b0, "R1 mem_en", int'(mem_en), 0);

    // R10 current-address read of erased array
    rd(1'b0, 0, v);
    chk(v == 8'hFF, "R10 erased byte", int'(v), 255);
    chk(addr_cnt == AW'(1), "R10 counter step", int'(addr_cnt), 1);

    // R2 session starting near row end, later addresses are garbage
    put(2*PAGE + 14, 8'h11);
    put(7, 8'h22);
    put(999, 8'h33);
    put(0, 8'h44);
    put(513, 8'h55);
    do_commit("R2 wrap session");
    check_row(2, "R2 row contents");
    check_row(3, "R2 next row untouched");

    // R3 overfill a page
    for (int i = 0; i < PAGE + 4; i++) put(5*PAGE + (i == 0 ? 0 : 3), 8'(i + 8'h60));
    do_commit("R3 overfill");
    check_row(5, "R3 row contents");

    // R4 single-byte merge into a full row
    for (int i = 0; i < PAGE; i++) put(7*PAGE, 8'(8'h90 + i));
    do_commit("R4 fill");
    put(7*PAGE + 5, 8'hC7);
    do_commit("R4 single");
    check_row(7, "R4 merge keeps neighbours");

    // R6 every single-bit flip of word 20 (row 5, offsets 0..3)
    for (int b = 0; b < 38; b++) begin
      flip(20, b);
      rd(1'b1, 80, v);
      chk(v == model[80], "R6 corrected byte 0", int'(v), int'(model[80]));
      for (int j = 1; j < 4; j++) begin
        rd(1'b0, 0, v);
        chk(v == model[80 + j], "R6 corrected byte", int'(v), int'(model[80 + j]));
      end
      flip(20, b);
    end

    // R10 counter wrap at top address
    rd(1'b1, NBYTE - 1, v);
    chk(v == model[NBYTE-1], "R10 top byte", int'(v), int'(model[NBYTE-1]));
    chk(addr_cnt == '0, "R10 counter wrap", int'(addr_cnt), 0);
    rd(1'b0, 0, v);
    chk(v == model[0], "R10 read after wrap", int'(v), int'(model[0]));
    chk(addr_cnt == AW'(1), "R10 counter after wrap", int'(addr_cnt), 1);

    // R9 abort drops staged bytes, array and counter unchanged
    for (int i = 0; i < 4; i++) put(9*PAGE, 8'(8'hA0 + i));
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    stage_clear();
    chk(addr_cnt == AW'(1), "R9 counter kept on abort", int'(addr_cnt), 1);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    chk(busy == 1'b0, "R9 empty commit ignored", int'(busy), 0);
    put(10*PAGE + 8, 8'h3C);
    do_commit("R9 after abort");
    check_row(9, "R9 aborted row unchanged");
    check_row(10, "R9 mask cleared");

    // R7 requests during busy are ignored
    put(12*PAGE, 8'h5A);
    for (int i = 0; i < PAGE; i++) if (st_val[i]) model[12*PAGE + i] = st_data[i];
    stage_clear();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    wr_stb = 1'b1; wr_addr = AW'(13*PAGE); wr_data = 8'hEE;
    rd_req = 1'b1; rd_load = 1'b1; rd_addr = AW'(3); abort = 1'b1;
    n = 0; saw_rd = 1'b0;
    while (busy && n < 1000) begin
      n++;
      if (n == 4) begin wr_stb = 1'b0; rd_req = 1'b0; rd_load = 1'b0; abort = 1'b0; end
      if (rd_valid) saw_rd = 1'b1;
      @(negedge clk);
    end
    chk(n == WCYC, "R7 busy length with traffic", n, WCYC);
    chk(saw_rd == 1'b0, "R7 no read during busy", int'(saw_rd), 0);
    chk(addr_cnt == AW'(12*PAGE + 1), "R7 counter untouched by read", int'(addr_cnt), 12*PAGE + 1);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    chk(busy == 1'b0, "R7 write during busy not staged", int'(busy), 0);
    check_row(12, "R7 committed row");
    check_row(13, "R7 ignored write row");

    // R11 commit beats write in the same cycle
    put(11*PAGE, 8'hA1);
    for (int i = 0; i < PAGE; i++) if (st_val[i]) model[11*PAGE + i] = st_data[i];
    stage_clear();
    commit = 1'b1; wr_stb = 1'b1; wr_addr = AW'(11*PAGE + 1); wr_data = 8'hB2;
    @(negedge clk);
    commit = 1'b0; wr_stb = 1'b0;
    wait_busy(n);
    chk(n == WCYC, "R11 commit won", n, WCYC);
    // R11 abort beats commit in the same cycle
    put(11*PAGE + 2, 8'hC3);
    stage_clear();
    abort = 1'b1; commit = 1'b1;
    @(negedge clk);
    abort = 1'b0; commit = 1'b0;
    chk(busy == 1'b0, "R11 abort won", int'(busy), 0);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    chk(busy == 1'b0, "R11 buffer empty after abort", int'(busy), 0);
    check_row(11, "R11 row contents");

    // R5 every stored codeword matches the bench encoding
    for (int w = 0; w < NWORD; w++) begin
      logic [37:0] e;
      e = tb_pack({model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]});
      chk(arr[w] == e, "R5 codeword", int'(arr[w][37:32]), int'(e[37:32]));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
    end
  end
endmodule